// File: doc/BRIEF.md
# Variable Bit Field Insert Unit

This block writes a field of variable width into a 64-bit value held as a pair of 32-bit registers. Each request gives a 32-bit source operand, a 32-bit bit position, an 8-bit field width and the current 64-bit pair contents. The lowest `width` bits of the source replace bits `[pos+width-1 : pos]` of the pair. Every other bit is taken unchanged from the supplied pair value. Because the position may be as high as 31 and the width as large as 32, a field can cross from the low register into the high one. The block therefore reports a separate write strobe for each half, so the register file only rewrites the registers the field actually touches.

A request is accepted on any cycle in which `req_valid` is high. The result is registered, so it appears one cycle later together with a single-cycle `done_o` pulse. A small state machine classifies each request and selects what that pulse carries:

- `ST_IDLE`: nothing is presented.
- `ST_WRITE`: a legal, non-empty field is reported, with its write strobes.
- `ST_SKIP`: a width of zero is reported as completed, with no write.
- `ST_FAULT`: an illegal operand is reported, with the destination left unchanged.

From any state, the next state is chosen the same way:

- idle→idle when no request arrives.
- →write for a legal non-empty request.
- →skip for a zero width.
- →fault for an illegal request.

The four condition flags presented with a request are handed back unchanged alongside the result.

Top module: `bfi_insert_unit`

## Requirements
- R1: When `done_o` is high for a legal request with width w (1..32) and position p (0..31), bits `[p+w-1 : p]` of `result_o` equal bits `[w-1:0]` of the source.
- R2: For a legal request, every bit of `result_o` outside `[p+w-1 : p]` equals the same bit of the base value.
- R3: A width of zero causes no write and no fault, whatever the position. `done_o` still pulses, and `result_o` equals the base value.
- R4: A width above 32 raises `fault_o` together with `done_o`. Neither write strobe asserts, and `result_o` equals the base value.
- R5: A nonzero width with a position above 31 raises `fault_o`, with no write and `result_o` equal to the base value.
- R6: `we_lo_o` is high exactly when the field covers at least one of bits 0..31. `we_hi_o` is high exactly when it covers at least one of bits 32..63. Both strobes are qualified by `done_o` and cleared on a fault.
- R7: `flags_o` equals the 4-bit `flags_i` presented with the request, in the cycle `done_o` is high.
- R8: `done_o` is high for exactly the cycle after each cycle in which `req_valid` is high. Back-to-back requests each produce their own pulse, and no pulse occurs without a request.
- R9: While reset is asserted (`rst_n` low), and until the first request, `done_o`, `fault_o`, `we_lo_o` and `we_hi_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| src_i | input | 32 | Source operand whose low bits form the field |
| pos_i | input | 32 | Bit position of the field's lowest bit |
| size_i | input | 8 | Field width in bits |
| base_i | input | 64 | Current register-pair value (high register in bits 63:32) |
| flags_i | input | 4 | Condition flags to pass through |
| result_o | output | 64 | Updated register-pair value |
| we_lo_o | output | 1 | Write strobe for bits 31:0 |
| we_hi_o | output | 1 | Write strobe for bits 63:32 |
| fault_o | output | 1 | Reserved-operand fault |
| done_o | output | 1 | Completion pulse |
| flags_o | output | 4 | Condition flags, unchanged |

## Verification
The bench aims at fields that straddle the two halves, including the widest case at position 31 with width 32. A design with an off-by-one mask or a truncated shift would corrupt bit 31 or 32, or would miss `we_hi_o`.

It checks the legality boundaries:

- width 32 against 33;
- position 31 against 32;
- a zero width paired with a huge position.

A design that tested position before width would raise a false fault in the last case. Source bits above the width are set to ones, so a missing mask would overwrite base bits outside the field. Back-to-back requests expose a state machine that swallows the second pulse.

// File: rtl/bfi_pkg.sv
package bfi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_SKIP  = 2'd2,
        ST_FAULT = 2'd3
    } bfi_state_e;

    typedef struct packed {
        logic fault;
        logic empty;
    } bfi_class_t;
endpackage

// File: rtl/bfi_classify.sv
module bfi_classify #(
    parameter int WORD_W = 32,
    parameter int SIZE_W = 8,
    localparam int POS_W = $clog2(WORD_W),
    localparam int LEN_W = $clog2(WORD_W) + 1
) (
    input  logic [WORD_W-1:0] pos_i,
    input  logic [SIZE_W-1:0] size_i,
    output bfi_pkg::bfi_class_t cls_o,
    output logic [POS_W-1:0]  pos_lo_o,
    output logic [LEN_W-1:0]  len_o
);
    logic size_zero;
    logic size_big;
    logic pos_big;

    always_comb begin
        size_zero = (size_i == '0);
        size_big  = (32'(size_i) > 32'(WORD_W));
        pos_big   = (pos_i > WORD_W'(WORD_W - 1));
        // Zero width wins over a bad position; width check is independent.
        cls_o.empty = size_zero;
        cls_o.fault = size_big || (!size_zero && pos_big);
        pos_lo_o    = pos_i[POS_W-1:0];
        len_o       = size_big ? '0 : size_i[LEN_W-1:0];
    end
endmodule

// File: rtl/bfi_mask_gen.sv
module bfi_mask_gen #(
    parameter int WORD_W = 32,
    localparam int POS_W = $clog2(WORD_W),
    localparam int LEN_W = $clog2(WORD_W) + 1,
    localparam int PAIR_W = 2 * WORD_W,
    localparam int IDX_W = $clog2(PAIR_W) + 1
) (
    input  logic [POS_W-1:0]  pos_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [PAIR_W-1:0] mask_o,
    output logic              hit_lo_o,
    output logic              hit_hi_o
);
    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] hi_idx;

    always_comb begin
        lo_idx = IDX_W'(pos_i);
        hi_idx = IDX_W'(pos_i) + IDX_W'(len_i);
    end

    for (genvar b = 0; b < PAIR_W; b++) begin : g_bit
        localparam logic [IDX_W-1:0] BIDX = IDX_W'(b);
        assign mask_o[b] = (BIDX >= lo_idx) && (BIDX < hi_idx);
    end

    assign hit_lo_o = |mask_o[WORD_W-1:0];
    assign hit_hi_o = |mask_o[PAIR_W-1:WORD_W];
endmodule

// File: rtl/bfi_merge.sv
module bfi_merge #(
    parameter int WORD_W = 32,
    localparam int POS_W = $clog2(WORD_W),
    localparam int PAIR_W = 2 * WORD_W
) (
    input  logic [WORD_W-1:0] src_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic [PAIR_W-1:0] mask_i,
    input  logic [PAIR_W-1:0] base_i,
    output logic [PAIR_W-1:0] merged_o
);
    logic [PAIR_W-1:0] placed;

    always_comb begin
        placed   = {{WORD_W{1'b0}}, src_i} << pos_i;
        merged_o = (base_i & ~mask_i) | (placed & mask_i);
    end
endmodule

// File: rtl/bfi_insert_unit.sv
module bfi_insert_unit #(
    parameter int WORD_W = 32,
    parameter int SIZE_W = 8,
    parameter int FLAG_W = 4,
    localparam int POS_W = $clog2(WORD_W),
    localparam int LEN_W = $clog2(WORD_W) + 1,
    localparam int PAIR_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] src_i,
    input  logic [WORD_W-1:0] pos_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [PAIR_W-1:0] base_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [PAIR_W-1:0] result_o,
    output logic              we_lo_o,
    output logic              we_hi_o,
    output logic              fault_o,
    output logic              done_o,
    output logic [FLAG_W-1:0] flags_o
);
    import bfi_pkg::*;

    bfi_class_t        cls;
    logic [POS_W-1:0]  pos_lo;
    logic [LEN_W-1:0]  len;
    logic [PAIR_W-1:0] mask;
    logic              hit_lo;
    logic              hit_hi;
    logic [PAIR_W-1:0] merged;

    bfi_state_e        state_q;
    bfi_state_e        state_d;
    logic [PAIR_W-1:0] result_q;
    logic              hit_lo_q;
    logic              hit_hi_q;
    logic [FLAG_W-1:0] flags_q;

    bfi_classify #(.WORD_W(WORD_W), .SIZE_W(SIZE_W)) u_cls (
        .pos_i    (pos_i),
        .size_i   (size_i),
        .cls_o    (cls),
        .pos_lo_o (pos_lo),
        .len_o    (len)
    );

    bfi_mask_gen #(.WORD_W(WORD_W)) u_mask (
        .pos_i    (pos_lo),
        .len_i    (len),
        .mask_o   (mask),
        .hit_lo_o (hit_lo),
        .hit_hi_o (hit_hi)
    );

    bfi_merge #(.WORD_W(WORD_W)) u_merge (
        .src_i    (src_i),
        .pos_i    (pos_lo),
        .mask_i   (mask),
        .base_i   (base_i),
        .merged_o (merged)
    );

    // Next-state selection: every state leaves the same way.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_WRITE, ST_SKIP, ST_FAULT: begin
                if (!req_valid)     state_d = ST_IDLE;
                else if (cls.fault) state_d = ST_FAULT;
                else if (cls.empty) state_d = ST_SKIP;
                else                state_d = ST_WRITE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Captured request data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            hit_lo_q <= 1'b0;
            hit_hi_q <= 1'b0;
            flags_q  <= '0;
        end else if (req_valid) begin
            result_q <= (cls.fault || cls.empty) ? base_i : merged;
            hit_lo_q <= hit_lo;
            hit_hi_q <= hit_hi;
            flags_q  <= flags_i;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        result_o = result_q;
        flags_o  = flags_q;
        we_lo_o  = 1'b0;
        we_hi_o  = 1'b0;
        fault_o  = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WRITE: begin
                done_o  = 1'b1;
                we_lo_o = hit_lo_q;
                we_hi_o = hit_hi_q;
            end
            ST_SKIP: done_o = 1'b1;
            ST_FAULT: begin
                done_o  = 1'b1;
                fault_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bfi_insert_chk.sv
module bfi_insert_chk #(
    parameter int WORD_W = 32,
    parameter int SIZE_W = 8,
    parameter int FLAG_W = 4,
    localparam int PAIR_W = 2 * WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [SIZE_W-1:0] size_i,
    input logic [PAIR_W-1:0] base_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [PAIR_W-1:0] result_o,
    input logic              we_lo_o,
    input logic              we_hi_o,
    input logic              fault_o,
    input logic              done_o,
    input logic [FLAG_W-1:0] flags_o
);
    // R8
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) == done_o);

    // R4
    fault_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!we_lo_o && !we_hi_o && done_o));

    // R5
    fault_keeps_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (result_o == $past(base_i)));

    // R3
    empty_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(size_i) == '0) |->
            (!we_lo_o && !we_hi_o && !fault_o && result_o == $past(base_i)));

    // R7
    flags_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flags_o == $past(flags_i)));

    // R6
    strobe_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo_o || we_hi_o) |-> done_o);
endmodule

bind bfi_insert_unit bfi_insert_chk #(
    .WORD_W(WORD_W), .SIZE_W(SIZE_W), .FLAG_W(FLAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .size_i    (size_i),
    .base_i    (base_i),
    .flags_i   (flags_i),
    .result_o  (result_o),
    .we_lo_o   (we_lo_o),
    .we_hi_o   (we_hi_o),
    .fault_o   (fault_o),
    .done_o    (done_o),
    .flags_o   (flags_o)
);

// File: tb/sim_bfi_insert_unit.sv
module sim_bfi_insert_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] src_i = '0;
    logic [31:0] pos_i = '0;
    logic [7:0]  size_i = '0;
    logic [63:0] base_i = '0;
    logic [3:0]  flags_i = '0;
    logic [63:0] result_o;
    logic        we_lo_o, we_hi_o, fault_o, done_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bfi_insert_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .src_i(src_i),
        .pos_i(pos_i), .size_i(size_i), .base_i(base_i), .flags_i(flags_i),
        .result_o(result_o), .we_lo_o(we_lo_o), .we_hi_o(we_hi_o),
        .fault_o(fault_o), .done_o(done_o), .flags_o(flags_o)
    );

    localparam int NV = 11;
    localparam logic [31:0] V_SRC [NV] = '{
        32'hFFFF_FFA5, 32'hFFFF_FFFF, 32'h0000_00C3, 32'h8000_0001,
        32'h1234_5678, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'h0000_0000, 32'hDEAD_BEEF, 32'h0000_0001};
    localparam logic [31:0] V_POS [NV] = '{
        32'd0, 32'd4, 32'd28, 32'd31, 32'd0, 32'd32, 32'd3, 32'd100,
        32'd16, 32'd31, 32'd31};
    localparam logic [7:0] V_SIZE [NV] = '{
        8'd8, 8'd4, 8'd8, 8'd32, 8'd32, 8'd1, 8'd33, 8'd0,
        8'd1, 8'd1, 8'd2};
    localparam logic [63:0] V_BASE [NV] = '{
        64'h0, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0000,
        64'hAAAA_AAAA_5555_5555, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888,
        64'h9999_AAAA_BBBB_CCCC, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0, 64'h0};
    localparam logic [3:0] V_FLAGS [NV] = '{
        4'h1, 4'h2, 4'h4, 4'h8, 4'hF, 4'h5, 4'hA, 4'h3, 4'hC, 4'h6, 4'h9};

    // Expected values from the requirements: {fault, we_hi, we_lo, result}
    function automatic logic [66:0] model(input logic [31:0] s, input logic [31:0] p,
                                          input logic [7:0] w, input logic [63:0] b);
        logic [63:0] r = b;
        logic lo = 1'b0, hi = 1'b0, f;
        f = (w > 8'd32) || (w != 0 && p > 32'd31);
        if (!f && w != 0) begin
            for (int i = 0; i < 64; i++) begin
                if (i >= int'(p) && i < int'(p) + int'(w)) begin
                    r[i] = s[i - int'(p)];
                    if (i < 32) lo = 1'b1; else hi = 1'b1;
                end
            end
        end
        return {f, hi, lo, r};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] s, input logic [31:0] p,
                         input logic [7:0] w, input logic [63:0] b, input logic [3:0] fl);
        logic [66:0] e;
        string rq;
        e = model(s, p, w, b);
        @(negedge clk);
        src_i = s; pos_i = p; size_i = w; base_i = b; flags_i = fl; req_valid = 1'b1;
        @(posedge clk);
        #2;
        if (e[66])        rq = (w > 8'd32) ? "R4" : "R5";
        else if (w == 0)  rq = "R3";
        else              rq = "R1/R2";
        check(rq, "result", result_o, e[63:0]);
        check(rq, "fault", 64'(fault_o), 64'(e[66]));
        check("R6", "we_lo", 64'(we_lo_o), 64'(e[64]));
        check("R6", "we_hi", 64'(we_hi_o), 64'(e[65]));
        check("R8", "done", 64'(done_o), 64'd1);
        check("R7", "flags", 64'(flags_o), 64'(fl));
    endtask

    task automatic idle_check;
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #2;
        check("R8", "done idle", 64'(done_o), 64'd0);
        check("R6", "we idle", 64'({we_hi_o, we_lo_o}), 64'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R9 reset state
        check("R9", "done rst", 64'(done_o), 64'd0);
        check("R9", "fault rst", 64'(fault_o), 64'd0);
        check("R9", "we rst", 64'({we_hi_o, we_lo_o}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R9", "done after rst", 64'(done_o), 64'd0);

        for (int k = 0; k < NV; k++) begin
            apply(V_SRC[k], V_POS[k], V_SIZE[k], V_BASE[k], V_FLAGS[k]);
            idle_check();
        end

        // R8 back-to-back requests, each with its own pulse
        apply(32'h0000_000F, 32'd30, 8'd4, 64'h0, 4'h7);
        apply(32'h0000_0000, 32'd0, 8'd32, 64'hFFFF_FFFF_FFFF_FFFF, 4'h1);
        apply(32'hFFFF_FFFF, 32'd31, 8'd33, 64'h0123_0000_0000_3210, 4'h2);
        idle_check();

        // R5 boundary: position 31 legal, 32 faults for the same width
        apply(32'h1, 32'd31, 8'd1, 64'h0, 4'h0);
        apply(32'h1, 32'd32, 8'd1, 64'h0, 4'h0);
        idle_check();

        // R3 zero width with a huge position
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd0, 64'h0F0F_0F0F_0F0F_0F0F, 4'hE);
        idle_check();

        // R4 largest width value
        apply(32'hFFFF_FFFF, 32'd0, 8'd255, 64'h2468_ACE0_1357_9BDF, 4'hB);
        idle_check();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule